// File: doc/BRIEF.md
# Fast-Channel Mailbox Register Set

This block gives two processors a set of single-word mailbox slots. Each slot is a 32-bit register on a simple word-wide register bus. The sending side writes one word into a slot. That write stores the payload and raises the slot's pending bit in a shared status register, so each slot acts as a doorbell that carries data.

The receiving side takes interrupts. It enables slots one at a time through an enable register, and an interrupt output follows any slot that is both pending and enabled. The handler reads the status register to find pending slots, then reads each slot's word. It acknowledges a slot by writing a one to the matching bit of a clear register. The sending side gets no completion indication of any kind.

The slot count, data width, address width, register offsets and the status bit position are all parameters. Two further parameters pick variants: whether slot data is reset, and whether the interrupt output is registered.

Top module: `fmb_fast_mailbox`

## Requirements
- R1: After reset, every slot reads 0x00000000, and the status and enable registers read 0. Both `rx_irq` and `slot_status` are 0.
- R2: A bus write to slot n (byte address 0x8C + 4*n, n = 0..7) stores the write data. Reading that address returns it from the cycle after the write until the slot is written again.
- R3: A write to slot n sets status bit (9 + n), visible at 0xC8 and on `slot_status[n]` from the cycle after the write. The other status bits do not change.
- R4: Reads of any address have no effect on status, on the enable register or on slot data. Status changes only on a slot write or a clear write.
- R5: Writing the clear register at 0xC4 clears each status bit (9 + n) whose write-data bit is 1. Status bits written with 0 keep their value, and write-data bits outside 9..16 have no effect.
- R6: The enable register at 0xC0 stores write-data bits 9..16 and reads them back in the same positions. All other bits read as 0.
- R7: `rx_irq` is 1 exactly when at least one slot has both its status bit and its enable bit set. It is updated in the same cycle as those registers.
- R8: A write to a slot whose status bit is already set replaces the stored word, and the status bit stays set.
- R9: Bus writes to the status address 0xC8 have no effect. Reads from any address that is not a slot, 0xC0 or 0xC8 return 0, and this includes misaligned slot addresses.
- R10: The clear register at 0xC4 always reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe; the write happens on the rising edge while it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rx_irq | output | 1 | Receive-side interrupt |
| slot_status | output | 8 | Pending bit of each slot |

## Verification
The assertions assume that `bus_wr`, `bus_addr` and `bus_wdata` are driven to known values at every clock edge once reset is released. They also assume only one access per cycle, so a slot write and a clear never arrive together. The bench meets this by changing inputs only after a rising edge has passed, by holding `bus_wr` low during reset, and by issuing one register operation per transaction. Random stimulus draws slot indices, clear masks, enable values and addresses with a fixed seed. Directed cases cover slots 0 and 7, a write to a slot that is already pending, clear masks that touch only bits outside the status field, and unmapped reads.

// File: rtl/fmb_pkg.sv
package fmb_pkg;
   // Kind of register selected by the current bus address
   typedef enum logic [2:0] {
      ACC_NONE   = 3'd0,
      ACC_SLOT   = 3'd1,
      ACC_ENABLE = 3'd2,
      ACC_CLEAR  = 3'd3,
      ACC_STATUS = 3'd4
   } acc_kind_e;
endpackage

// File: rtl/fmb_addr_dec.sv
module fmb_addr_dec
   import fmb_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned NUM_SLOTS   = 8,
   parameter int unsigned SLOT_BASE   = 32'h8C,
   parameter int unsigned SLOT_STRIDE = 4,
   parameter int unsigned ENA_ADDR    = 32'hC0,
   parameter int unsigned CLR_ADDR    = 32'hC4,
   parameter int unsigned STAT_ADDR   = 32'hC8
) (
   input  logic [ADDR_W-1:0]    addr,
   output acc_kind_e            kind,
   output logic [NUM_SLOTS-1:0] slot_hit
);
   localparam int unsigned SLOT_LAST = SLOT_BASE + SLOT_STRIDE * (NUM_SLOTS - 1);
   localparam logic [ADDR_W-1:0] ENA_A  = ADDR_W'(ENA_ADDR);
   localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CLR_ADDR);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

   if (SLOT_LAST >= (1 << ADDR_W)) begin : g_chk_span
      $error("fmb_addr_dec: slot window does not fit the address width");
   end
   if ((SLOT_STRIDE % 4) != 0 || SLOT_STRIDE == 0) begin : g_chk_stride
      $error("fmb_addr_dec: slot stride must be a nonzero multiple of 4");
   end
   if ((ENA_ADDR >= SLOT_BASE && ENA_ADDR <= SLOT_LAST) ||
       (CLR_ADDR >= SLOT_BASE && CLR_ADDR <= SLOT_LAST) ||
       (STAT_ADDR >= SLOT_BASE && STAT_ADDR <= SLOT_LAST)) begin : g_chk_overlap
      $error("fmb_addr_dec: control register lies inside the slot window");
   end
   if (ENA_ADDR == CLR_ADDR || ENA_ADDR == STAT_ADDR || CLR_ADDR == STAT_ADDR) begin : g_chk_dup
      $error("fmb_addr_dec: control registers share an address");
   end

   // One comparator per slot
   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot_cmp
      localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(SLOT_BASE + SLOT_STRIDE * i);
      assign slot_hit[i] = (addr == SLOT_A);
   end

   always_comb begin
      kind = ACC_NONE;
      if (|slot_hit) begin
         kind = ACC_SLOT;
      end else if (addr == ENA_A) begin
         kind = ACC_ENABLE;
      end else if (addr == CLR_A) begin
         kind = ACC_CLEAR;
      end else if (addr == STAT_A) begin
         kind = ACC_STATUS;
      end
   end
endmodule

// File: rtl/fmb_slot_bank.sv
module fmb_slot_bank #(
   parameter int unsigned NUM_SLOTS  = 8,
   parameter int unsigned DATA_W     = 32,
   parameter bit          DATA_RESET = 1'b1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_SLOTS-1:0]             slot_we,
   input  logic [DATA_W-1:0]                wdata,
   output logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q
);
   if (NUM_SLOTS < 1) begin : g_chk_n
      $error("fmb_slot_bank: at least one slot is needed");
   end

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      if (DATA_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q[i] <= '0;
            end else if (slot_we[i]) begin
               slot_q[i] <= wdata;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (slot_we[i]) begin
               slot_q[i] <= wdata;
            end
         end
      end
   end
endmodule

// File: rtl/fmb_irq_ctrl.sv
module fmb_irq_ctrl #(
   parameter int unsigned NUM_SLOTS = 8,
   parameter bit          IRQ_REG   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] set_pulse,
   input  logic                 clr_we,
   input  logic                 ena_we,
   input  logic [NUM_SLOTS-1:0] field,
   output logic [NUM_SLOTS-1:0] status_q,
   output logic [NUM_SLOTS-1:0] enable_q,
   output logic                 irq
);
   logic [NUM_SLOTS-1:0] clr_mask;
   logic [NUM_SLOTS-1:0] status_d;
   logic                 irq_raw;

   assign clr_mask = clr_we ? field : '0;

   // A set in the same cycle wins over a clear of the same bit
   assign status_d = (status_q & ~clr_mask) | set_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
      end else begin
         status_q <= status_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
      end else if (ena_we) begin
         enable_q <= field;
      end
   end

   assign irq_raw = |(status_q & enable_q);

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq <= 1'b0;
         end else begin
            irq <= irq_raw;
         end
      end
   end else begin : g_irq_comb
      assign irq = irq_raw;
   end
endmodule

// File: rtl/fmb_rd_mux.sv
module fmb_rd_mux
   import fmb_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned BIT_BASE  = 9
) (
   input  acc_kind_e                        kind,
   input  logic [NUM_SLOTS-1:0]             slot_hit,
   input  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q,
   input  logic [NUM_SLOTS-1:0]             status_q,
   input  logic [NUM_SLOTS-1:0]             enable_q,
   output logic [DATA_W-1:0]                rdata
);
   if (BIT_BASE + NUM_SLOTS > DATA_W) begin : g_chk_field
      $error("fmb_rd_mux: status field does not fit the data width");
   end

   logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_term;
   logic [DATA_W-1:0]                slot_word;
   logic [DATA_W-1:0]                stat_word;
   logic [DATA_W-1:0]                ena_word;

   // AND-OR selection: the slot hits are one-hot by address decode
   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_term
      assign slot_term[i] = slot_q[i] & {DATA_W{slot_hit[i]}};
   end

   always_comb begin
      slot_word = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         slot_word = slot_word | slot_term[i];
      end
   end

   always_comb begin
      stat_word = '0;
      ena_word  = '0;
      stat_word[BIT_BASE +: NUM_SLOTS] = status_q;
      ena_word[BIT_BASE +: NUM_SLOTS]  = enable_q;
   end

   always_comb begin
      case (kind)
         ACC_SLOT:   rdata = slot_word;
         ACC_ENABLE: rdata = ena_word;
         ACC_STATUS: rdata = stat_word;
         default:    rdata = '0;
      endcase
   end
endmodule

// File: rtl/fmb_fast_mailbox.sv
module fmb_fast_mailbox
   import fmb_pkg::*;
#(
   parameter int unsigned NUM_SLOTS   = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SLOT_BASE   = 32'h8C,
   parameter int unsigned SLOT_STRIDE = 4,
   parameter int unsigned ENA_ADDR    = 32'hC0,
   parameter int unsigned CLR_ADDR    = 32'hC4,
   parameter int unsigned STAT_ADDR   = 32'hC8,
   parameter int unsigned BIT_BASE    = 9,
   parameter bit          DATA_RESET  = 1'b1,
   parameter bit          IRQ_REG     = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic                 rx_irq,
   output logic [NUM_SLOTS-1:0] slot_status
);
   if (BIT_BASE + NUM_SLOTS > DATA_W) begin : g_chk_field
      $error("fmb_fast_mailbox: status field exceeds data width");
   end
   if (DATA_W < 8) begin : g_chk_w
      $error("fmb_fast_mailbox: data width too small");
   end

   acc_kind_e                        kind;
   logic [NUM_SLOTS-1:0]             slot_hit;
   logic [NUM_SLOTS-1:0]             slot_we;
   logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q;
   logic [NUM_SLOTS-1:0]             status_q;
   logic [NUM_SLOTS-1:0]             enable_q;
   logic [NUM_SLOTS-1:0]             wfield;
   logic                             clr_we;
   logic                             ena_we;

   fmb_addr_dec #(
      .ADDR_W      (ADDR_W),
      .NUM_SLOTS   (NUM_SLOTS),
      .SLOT_BASE   (SLOT_BASE),
      .SLOT_STRIDE (SLOT_STRIDE),
      .ENA_ADDR    (ENA_ADDR),
      .CLR_ADDR    (CLR_ADDR),
      .STAT_ADDR   (STAT_ADDR)
   ) u_dec (
      .addr     (bus_addr),
      .kind     (kind),
      .slot_hit (slot_hit)
   );

   assign slot_we = slot_hit & {NUM_SLOTS{bus_wr}};
   assign clr_we  = bus_wr && (kind == ACC_CLEAR);
   assign ena_we  = bus_wr && (kind == ACC_ENABLE);
   assign wfield  = bus_wdata[BIT_BASE +: NUM_SLOTS];

   fmb_slot_bank #(
      .NUM_SLOTS  (NUM_SLOTS),
      .DATA_W     (DATA_W),
      .DATA_RESET (DATA_RESET)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .slot_we (slot_we),
      .wdata   (bus_wdata),
      .slot_q  (slot_q)
   );

   fmb_irq_ctrl #(
      .NUM_SLOTS (NUM_SLOTS),
      .IRQ_REG   (IRQ_REG)
   ) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_pulse (slot_we),
      .clr_we    (clr_we),
      .ena_we    (ena_we),
      .field     (wfield),
      .status_q  (status_q),
      .enable_q  (enable_q),
      .irq       (rx_irq)
   );

   fmb_rd_mux #(
      .NUM_SLOTS (NUM_SLOTS),
      .DATA_W    (DATA_W),
      .BIT_BASE  (BIT_BASE)
   ) u_rd (
      .kind     (kind),
      .slot_hit (slot_hit),
      .slot_q   (slot_q),
      .status_q (status_q),
      .enable_q (enable_q),
      .rdata    (bus_rdata)
   );

   assign slot_status = status_q;
endmodule

// File: rtl/fmb_fast_mailbox_chk.sv
module fmb_fast_mailbox_chk #(
   parameter int unsigned NUM_SLOTS   = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SLOT_BASE   = 32'h8C,
   parameter int unsigned SLOT_STRIDE = 4,
   parameter int unsigned CLR_ADDR    = 32'hC4,
   parameter int unsigned BIT_BASE    = 9
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic                 bus_wr,
   input logic [DATA_W-1:0]    bus_wdata,
   input logic [DATA_W-1:0]    bus_rdata,
   input logic                 rx_irq,
   input logic [NUM_SLOTS-1:0] slot_status
);
   localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_ADDR);

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot_prop
      localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(SLOT_BASE + SLOT_STRIDE * i);

      // R3 and R8: a slot write leaves its pending bit set
      a_r3_write_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == SLOT_A) |=> slot_status[i]);

      // R5: a one in the clear field drops the pending bit
      a_r5_clear_drops_status: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == CLR_A && bus_wdata[BIT_BASE + i]) |=> !slot_status[i]);

      // R2: the word just written reads back from its slot
      a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(bus_wr && bus_addr == SLOT_A) && bus_addr == SLOT_A)
            |-> bus_rdata == $past(bus_wdata));
   end

   // R4: without a write, status keeps its value
   a_r4_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(slot_status));

   // R7: the interrupt needs a pending slot
   a_r7_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> slot_status != '0);
endmodule

bind fmb_fast_mailbox fmb_fast_mailbox_chk #(
   .NUM_SLOTS   (NUM_SLOTS),
   .DATA_W      (DATA_W),
   .ADDR_W      (ADDR_W),
   .SLOT_BASE   (SLOT_BASE),
   .SLOT_STRIDE (SLOT_STRIDE),
   .CLR_ADDR    (CLR_ADDR),
   .BIT_BASE    (BIT_BASE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr    (bus_addr),
   .bus_wr      (bus_wr),
   .bus_wdata   (bus_wdata),
   .bus_rdata   (bus_rdata),
   .rx_irq      (rx_irq),
   .slot_status (slot_status)
);

// File: tb/fmb_fast_mailbox_tb.sv
module fmb_fast_mailbox_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_ENA  = 8'hC0;
   localparam logic [7:0] A_CLR  = 8'hC4;
   localparam logic [7:0] A_STAT = 8'hC8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_irq;
   logic [7:0]  slot_status;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] m_data [8];
   logic [7:0]  m_stat;
   logic [7:0]  m_ena;

   always #(CLK_PERIOD / 2) clk = ~clk;

   fmb_fast_mailbox dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (bus_addr),
      .bus_wr      (bus_wr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .rx_irq      (rx_irq),
      .slot_status (slot_status)
   );

   function automatic logic [7:0] slot_addr(int n);
      return 8'(8'h8C + 4 * n);
   endfunction

   function automatic logic [31:0] exp_read(logic [7:0] a);
      for (int n = 0; n < 8; n++) begin
         if (a == slot_addr(n)) return m_data[n];
      end
      if (a == A_ENA)  return {15'd0, m_ena, 9'd0};
      if (a == A_STAT) return {15'd0, m_stat, 9'd0};
      return 32'd0;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %08h expected %08h", tag, act, exp);
      end
   endtask

   task automatic do_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(posedge clk);
      #1;
      bus_wr = 1'b0;
      for (int n = 0; n < 8; n++) begin
         if (a == slot_addr(n)) begin
            m_data[n] = d;
            m_stat[n] = 1'b1;
         end
      end
      if (a == A_ENA) m_ena = d[16:9];
      if (a == A_CLR) m_stat = m_stat & ~d[16:9];
   endtask

   task automatic do_read(string tag, logic [7:0] a);
      bus_addr = a;
      #1;
      check(tag, bus_rdata, exp_read(a));
   endtask

   task automatic check_outs(string tag);
      check({tag, " status"}, {24'd0, slot_status}, {24'd0, m_stat});
      check({tag, " irq"}, {31'd0, rx_irq}, {31'd0, |(m_stat & m_ena)});
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog (all requirements) actual running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] r0;
      void'($urandom(32'd20240611));
      for (int n = 0; n < 8; n++) m_data[n] = '0;
      m_stat = '0;
      m_ena  = '0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int n = 0; n < 8; n++) do_read("R1 slot after reset", slot_addr(n));
      do_read("R1 status after reset", A_STAT);
      do_read("R1 enable after reset", A_ENA);
      check_outs("R1 reset outputs");

      // R2 R3 boundary slots
      do_write(slot_addr(0), 32'hA5A5_0001);
      do_read("R2 slot0 readback", slot_addr(0));
      do_read("R3 status after slot0", A_STAT);
      check_outs("R3 slot0 outputs");
      do_write(slot_addr(7), 32'hDEAD_BEEF);
      do_read("R2 slot7 readback", slot_addr(7));
      do_read("R3 status after slot7", A_STAT);

      // R4 repeated reads leave state alone
      do_read("R4 status read 1", A_STAT);
      repeat (3) @(negedge clk);
      do_read("R4 status read 2", A_STAT);
      do_read("R4 slot7 reread", slot_addr(7));
      check_outs("R4 after reads");

      // R8 overwrite pending slot
      do_write(slot_addr(3), 32'h1111_1111);
      do_write(slot_addr(3), 32'h2222_2222);
      do_read("R8 overwrite data", slot_addr(3));
      check_outs("R8 bit stays set");

      // R5 clear with bits only outside the field
      do_write(A_CLR, 32'hFFFE_01FF);
      do_read("R5 out-of-field clear ignored", A_STAT);
      do_write(A_CLR, 32'h0000_0200);
      do_read("R5 clear slot0 only", A_STAT);
      check_outs("R5 after clear");

      // R6 enable register field
      do_write(A_ENA, 32'hFFFF_FFFF);
      do_read("R6 enable readback all", A_ENA);
      check_outs("R7 irq with all enabled");
      do_write(A_ENA, 32'h0000_0200);
      check_outs("R7 enabled slot0 not pending");
      do_write(slot_addr(0), 32'h0BAD_F00D);
      check_outs("R7 irq on enabled pending");
      do_write(A_CLR, 32'h0001_FE00);
      check_outs("R7 irq drops after clear");

      // R9 status write ignored, unmapped reads
      do_write(slot_addr(5), 32'h5555_AAAA);
      do_write(A_STAT, 32'h0000_0000);
      do_read("R9 status write ignored", A_STAT);
      do_read("R9 misaligned slot addr", 8'h8D);
      do_read("R9 unmapped 0x88", 8'h88);
      do_read("R9 unmapped 0x00", 8'h00);
      do_read("R9 unmapped 0xCC", 8'hCC);
      r0 = 32'h0;
      check("R9 misaligned write no slot change", exp_read(slot_addr(0)), 32'h0BAD_F00D);
      do_write(8'h8E, 32'hFFFF_FFFF);
      do_read("R9 misaligned write ignored", slot_addr(0));
      check_outs("R9 misaligned write no status");

      // R10 clear register reads 0
      do_read("R10 clear reads zero", A_CLR);

      // Random phase
      for (int k = 0; k < 600; k++) begin
         int unsigned op;
         logic [7:0]  ra;
         op = $urandom_range(0, 9);
         if (op < 4) begin
            do_write(slot_addr(int'($urandom_range(0, 7))), $urandom());
         end else if (op < 6) begin
            do_write(A_CLR, $urandom());
         end else if (op < 7) begin
            do_write(A_ENA, $urandom());
         end else if (op < 8) begin
            do_write(A_STAT, $urandom());
         end else begin
            @(negedge clk);
         end
         check_outs("R7 random outputs");
         op = $urandom_range(0, 11);
         if (op < 8) ra = slot_addr(int'(op));
         else if (op == 8) ra = A_ENA;
         else if (op == 9) ra = A_STAT;
         else if (op == 10) ra = A_CLR;
         else ra = 8'($urandom());
         do_read("R2 random read", ra);
         do_read("R4 random status", A_STAT);
      end
      r0 = r0 + 0;

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule